// File: doc/BRIEF.md
# Test Pattern Sequence Generator

This block is a streaming source of diagnostic data for checking links and memories. Each output word comes with a valid strobe. The downstream consumer paces the block through a request input, which acts as that consumer's ready. Every cycle in which the block is running and request is high yields exactly one word.

The word content is chosen by two select inputs:
- a pseudo-random sequence from a maximal-length XNOR linear feedback shift register;
- an incrementing counter that wraps at a programmable modulo;
- a constant equal to the programmed initial value.

The initial value has two uses. It is the word the generator rests on while disabled, and it is the first word of every run.

The block also keeps a count of the words it has sent since it was enabled. A parameter places the outputs either in the same cycle as the request (combinational) or one cycle later (registered).

Control is a two-state machine:
- `ST_IDLE` (disabled): holds the generator at the initial value, clears the word count and emits nothing.
- `ST_RUN`: produces the sequence.

There are two transitions. START moves `ST_IDLE` to `ST_RUN` on the first clock edge that sees `enable` high. STOP moves `ST_RUN` back to `ST_IDLE` on the first edge that sees `enable` low.

Top module: `pattern_seq_gen`

## Requirements
- R1: While the machine is in ST_IDLE, out_valid stays low. With LATENCY=1, out_data shows init_val from the second cycle of a disabled stretch.
- R2: With pat_sel=0 and const_sel=0, each word is followed by the next state of an XNOR LFSR. The new bit is the XNOR of the tap bits and enters at bit 0, while the other bits move one place toward the MSB. Tap n means bit n-1; for DATA_W=16 the taps are 16, 15, 13 and 4. A seed of all zeros is legal, and from it the sequence runs 0, 1, 3, 7.
- R3: With pat_sel=1 and const_sel=0, each word is the previous word plus one.
- R4: In counter mode the word after mod_val-1 is 0 when mod_val is non-zero. With mod_val=0 the counter wraps from 2^DATA_W-1 to 0.
- R5: With const_sel=1, every valid word equals init_val, whatever pat_sel is.
- R6: The first word produced after the START transition equals init_val.
- R7: A word is produced, and the sequence advances, only in a running cycle with req=1. While req=0 the sequence holds its position.
- R8: tx_count is 0 in ST_IDLE. In ST_RUN it rises by one for each word produced, and it wraps at 2^CNT_W.
- R9: With LATENCY=0, out_valid and out_data are driven in the request cycle itself. With LATENCY=1, they appear one cycle after it.
- R10: A synchronous active-high rst puts the machine in ST_IDLE. It also clears out_valid and tx_count, and with LATENCY=1 it clears out_data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Run the generator when high; idle and rearm when low |
| pat_sel | input | 1 | 0 = LFSR data, 1 = counter data |
| const_sel | input | 1 | 1 = output init_val on every word |
| init_val | input | DATA_W | Seed, counter start and constant value |
| mod_val | input | DATA_W | Counter modulo, 0 = natural wrap |
| req | input | 1 | Downstream ready; one word per high cycle |
| out_data | output | DATA_W | Generated word |
| out_valid | output | 1 | out_data carries a produced word |
| tx_count | output | CNT_W | Words produced since enable |

## Verification
The assertions check the following on every cycle:
- no valid word without a matching request;
- silence and a cleared count once enable has been low long enough;
- the count never moving by more than one step;
- constant-mode words equal to the init value.

The values of the LFSR and counter sequences are left to the bench. So are the modulo wrap points, the first word of a run and the held position across request gaps. The bench compares both latency variants against a reference model, using directed corner cases and a seeded random phase.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    // Mask with bit (n-1) set for every non-zero tap n.
    function automatic logic [31:0] tap_set(input int a, input int b, input int c, input int d);
        logic [31:0] m;
        m = '0;
        if (a > 0) m[a-1] = 1'b1;
        if (b > 0) m[b-1] = 1'b1;
        if (c > 0) m[c-1] = 1'b1;
        if (d > 0) m[d-1] = 1'b1;
        return m;
    endfunction

    // Maximal-length XNOR taps per register width.
    function automatic logic [31:0] lfsr_taps(input int w);
        case (w)
            1:       return tap_set(1, 0, 0, 0);
            2:       return tap_set(2, 1, 0, 0);
            3:       return tap_set(3, 2, 0, 0);
            4:       return tap_set(4, 3, 0, 0);
            5:       return tap_set(5, 3, 0, 0);
            6:       return tap_set(6, 5, 0, 0);
            7:       return tap_set(7, 6, 0, 0);
            8:       return tap_set(8, 6, 5, 4);
            9:       return tap_set(9, 5, 0, 0);
            10:      return tap_set(10, 7, 0, 0);
            11:      return tap_set(11, 9, 0, 0);
            12:      return tap_set(12, 6, 4, 1);
            13:      return tap_set(13, 4, 3, 1);
            14:      return tap_set(14, 5, 3, 1);
            15:      return tap_set(15, 14, 0, 0);
            16:      return tap_set(16, 15, 13, 4);
            17:      return tap_set(17, 14, 0, 0);
            18:      return tap_set(18, 11, 0, 0);
            19:      return tap_set(19, 6, 2, 1);
            20:      return tap_set(20, 17, 0, 0);
            21:      return tap_set(21, 19, 0, 0);
            22:      return tap_set(22, 21, 0, 0);
            23:      return tap_set(23, 18, 0, 0);
            24:      return tap_set(24, 23, 22, 17);
            25:      return tap_set(25, 22, 0, 0);
            26:      return tap_set(26, 6, 2, 1);
            27:      return tap_set(27, 5, 2, 1);
            28:      return tap_set(28, 25, 0, 0);
            29:      return tap_set(29, 27, 0, 0);
            30:      return tap_set(30, 6, 4, 1);
            31:      return tap_set(31, 28, 0, 0);
            default: return tap_set(32, 22, 2, 1);
        endcase
    endfunction

endpackage

// File: rtl/pseq_ctrl.sv
// Run/idle state machine: START on enable high, STOP on enable low.
module pseq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    output logic run,
    output logic load
);
    import pseq_pkg::*;

    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)  state_d = ST_RUN;   // START
            ST_RUN:  if (!enable) state_d = ST_IDLE;  // STOP
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        run  = 1'b0;
        load = 1'b0;
        unique case (state_q)
            ST_IDLE: load = 1'b1;
            ST_RUN:  run  = 1'b1;
            default: load = 1'b1;
        endcase
    end
endmodule

// File: rtl/pseq_step.sv
// Next sequence value for LFSR or modulo counter.
module pseq_step #(
    parameter int W = 16,
    parameter logic [W-1:0] TAP_MASK = '1
) (
    input  logic [W-1:0] cur,
    input  logic         pat_sel,
    input  logic [W-1:0] mod_val,
    output logic [W-1:0] nxt
);
    logic [W-1:0] lfsr_nxt;
    logic [W-1:0] cnt_nxt;
    logic         fb;
    logic         wrap;

    assign fb = ~^(cur & TAP_MASK);

    generate
        if (W == 1) begin : g_one
            assign lfsr_nxt = fb;
        end else begin : g_wide
            assign lfsr_nxt = {cur[W-2:0], fb};
        end
    endgenerate

    assign wrap    = (mod_val != '0) && (cur == mod_val - 1'b1);
    assign cnt_nxt = wrap ? '0 : cur + 1'b1;
    assign nxt     = pat_sel ? cnt_nxt : lfsr_nxt;
endmodule

// File: rtl/pseq_txcount.sv
// Word counter, cleared while idle, natural wrap.
module pseq_txcount #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (clear) count <= '0;
        else if (inc)   count <= count + 1'b1;
    end
endmodule

// File: rtl/pattern_seq_gen.sv
module pattern_seq_gen #(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 32,
    parameter int LATENCY = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              pat_sel,
    input  logic              const_sel,
    input  logic [DATA_W-1:0] init_val,
    input  logic [DATA_W-1:0] mod_val,
    input  logic              req,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic [CNT_W-1:0]  tx_count
);
    localparam logic [DATA_W-1:0] TAP_MASK = DATA_W'(pseq_pkg::lfsr_taps(DATA_W));

    logic              run;
    logic              load;
    logic              fire;
    logic [DATA_W-1:0] cur_q;
    logic [DATA_W-1:0] cur_nxt;
    logic [DATA_W-1:0] word;

    pseq_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .enable (enable),
        .run    (run),
        .load   (load)
    );

    pseq_step #(
        .W        (DATA_W),
        .TAP_MASK (TAP_MASK)
    ) u_step (
        .cur     (cur_q),
        .pat_sel (pat_sel),
        .mod_val (mod_val),
        .nxt     (cur_nxt)
    );

    assign fire = run & req;
    assign word = const_sel ? init_val : cur_q;

    always_ff @(posedge clk) begin
        if (rst)       cur_q <= '0;
        else if (load) cur_q <= init_val;
        else if (fire) cur_q <= cur_nxt;
    end

    pseq_txcount #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (load),
        .inc   (fire),
        .count (tx_count)
    );

    generate
        if (LATENCY == 0) begin : g_comb
            assign out_valid = fire;
            assign out_data  = word;
        end else begin : g_reg
            logic              valid_q;
            logic [DATA_W-1:0] data_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    valid_q <= 1'b0;
                    data_q  <= '0;
                end else begin
                    valid_q <= fire;
                    if (fire)      data_q <= word;
                    else if (load) data_q <= init_val;
                end
            end
            assign out_valid = valid_q;
            assign out_data  = data_q;
        end
    endgenerate
endmodule

// File: rtl/pseq_checker.sv
module pseq_checker #(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 32,
    parameter int LATENCY = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              enable,
    input logic              const_sel,
    input logic [DATA_W-1:0] init_val,
    input logic              req,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic [CNT_W-1:0]  tx_count
);
    // R1: two low enable samples mean idle for the output stage
    a_r1_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
        (!$past(enable) && !$past(enable, 2)) |-> !out_valid);

    // R8: count is clear one cycle after the machine sits in idle
    a_r8_clear_when_off: assert property (@(posedge clk) disable iff (rst)
        !$past(enable, 2) |-> (tx_count == '0));

    // R8: count moves by at most one per cycle, or clears
    a_r8_single_step: assert property (@(posedge clk) disable iff (rst)
        (tx_count == $past(tx_count)) || (tx_count == CNT_W'($past(tx_count) + 1'b1)) || (tx_count == '0));

    generate
        if (LATENCY == 0) begin : g_l0
            // R7 R9: a word only in the request cycle
            a_r7_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> req);
            // R5: constant words equal init
            a_r5_const_word: assert property (@(posedge clk) disable iff (rst)
                (out_valid && const_sel) |-> (out_data == init_val));
        end else begin : g_l1
            // R7 R9: a word one cycle after its request
            a_r7_valid_needs_req: assert property (@(posedge clk) disable iff (rst)
                out_valid |-> $past(req));
            // R5: constant words equal init
            a_r5_const_word: assert property (@(posedge clk) disable iff (rst)
                (out_valid && $past(const_sel)) |-> (out_data == $past(init_val)));
        end
    endgenerate
endmodule

bind pattern_seq_gen pseq_checker #(
    .DATA_W  (DATA_W),
    .CNT_W   (CNT_W),
    .LATENCY (LATENCY)
) u_pseq_chk (
    .clk       (clk),
    .rst       (rst),
    .enable    (enable),
    .const_sel (const_sel),
    .init_val  (init_val),
    .req       (req),
    .out_data  (out_data),
    .out_valid (out_valid),
    .tx_count  (tx_count)
);

// File: tb/pattern_seq_gen_test.sv
module pattern_seq_gen_test;
    localparam int W = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst, enable, pat_sel, const_sel, req;
    logic [W-1:0] init_val, mod_val;
    logic [W-1:0] o1_data, o0_data;
    logic         o1_valid, o0_valid;
    logic [31:0]  o1_count, o0_count;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic         m_run, m_vq, m_dq_unused;
    logic [W-1:0] m_cur, m_dq;
    logic [31:0]  m_cnt;

    pattern_seq_gen #(.DATA_W(W), .CNT_W(32), .LATENCY(1)) uut (
        .clk(clk), .rst(rst), .enable(enable), .pat_sel(pat_sel), .const_sel(const_sel),
        .init_val(init_val), .mod_val(mod_val), .req(req),
        .out_data(o1_data), .out_valid(o1_valid), .tx_count(o1_count));

    pattern_seq_gen #(.DATA_W(W), .CNT_W(32), .LATENCY(0)) uut_comb (
        .clk(clk), .rst(rst), .enable(enable), .pat_sel(pat_sel), .const_sel(const_sel),
        .init_val(init_val), .mod_val(mod_val), .req(req),
        .out_data(o0_data), .out_valid(o0_valid), .tx_count(o0_count));

    function automatic logic [W-1:0] lfsr_next(input logic [W-1:0] c);
        return {c[14:0], ~(c[15] ^ c[14] ^ c[12] ^ c[3])};
    endfunction

    function automatic logic [W-1:0] cnt_next(input logic [W-1:0] c, input logic [W-1:0] m);
        if (m != 0 && c == m - 1'b1) return '0;
        return c + 1'b1;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic string data_tag();
        if (const_sel) return "R5 constant word";
        if (pat_sel)   return "R3 counter word";
        return "R2 lfsr word";
    endfunction

    // Called at a negedge with inputs set; returns at the next negedge.
    task automatic step();
        logic         fire;
        logic [W-1:0] word;
        #5;
        if (!rst) begin
            check("R9 comb valid", {31'd0, o0_valid}, {31'd0, m_run && req});
            check({data_tag(), " R9 comb"}, {16'd0, o0_data}, {16'd0, const_sel ? init_val : m_cur});
            check("R8 comb count", o0_count, m_cnt);
        end
        @(posedge clk);
        if (rst) begin
            m_run = 1'b0; m_cur = '0; m_cnt = '0; m_vq = 1'b0; m_dq = '0;
        end else begin
            fire = m_run && req;
            word = const_sel ? init_val : m_cur;
            m_vq = fire;
            if (fire)        m_dq = word;
            else if (!m_run) m_dq = init_val;
            m_cnt = !m_run ? 32'd0 : m_cnt + {31'd0, fire};
            if (!m_run)   m_cur = init_val;
            else if (fire) m_cur = pat_sel ? cnt_next(m_cur, mod_val) : lfsr_next(m_cur);
            m_run = enable;
        end
        @(negedge clk);
        check("R7 R9 reg valid", {31'd0, o1_valid}, {31'd0, m_vq});
        check({data_tag(), " R9 reg"}, {16'd0, o1_data}, {16'd0, m_dq});
        check("R8 reg count", o1_count, m_cnt);
    endtask

    task automatic restart(input logic p, input logic c, input logic [W-1:0] iv, input logic [W-1:0] mv);
        enable = 1'b0; req = 1'b1;
        step(); step();
        pat_sel = p; const_sel = c; init_val = iv; mod_val = mv;
        enable = 1'b1;
        step();
    endtask

    logic done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual %0d expected run end", 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        m_run = 1'b0; m_vq = 1'b0; m_dq_unused = 1'b0; m_cur = '0; m_dq = '0; m_cnt = '0;
        rst = 1'b1; enable = 1'b0; pat_sel = 1'b0; const_sel = 1'b0; req = 1'b0;
        init_val = 16'h1234; mod_val = '0;
        r = $urandom(32'd2024);
        @(negedge clk);
        step(); step(); step();
        // R10 reset state
        check("R10 reset valid", {31'd0, o1_valid}, 32'd0);
        check("R10 reset count", o1_count, 32'd0);
        check("R10 reset data", {16'd0, o1_data}, 32'd0);
        rst = 1'b0;

        // R1 disabled with request high
        req = 1'b1; init_val = 16'hABCD;
        step(); step(); step();
        check("R1 idle valid", {31'd0, o1_valid}, 32'd0);
        check("R1 idle data", {16'd0, o1_data}, 32'h0000ABCD);

        // R6 R3 counter from init
        restart(1'b1, 1'b0, 16'd5, 16'd0);
        step(); check("R6 first word", {16'd0, o1_data}, 32'd5);
        step(); check("R3 increment", {16'd0, o1_data}, 32'd6);
        step(); check("R3 increment", {16'd0, o1_data}, 32'd7);

        // R4 modulo 5 and R8 count
        restart(1'b1, 1'b0, 16'd0, 16'd5);
        for (int i = 0; i < 6; i++) step();
        check("R4 wrap at mod", {16'd0, o1_data}, 32'd0);
        check("R8 count six", o1_count, 32'd6);
        enable = 1'b0;
        step(); step();
        check("R8 cleared when off", o1_count, 32'd0);
        check("R1 off no valid", {31'd0, o1_valid}, 32'd0);

        // R4 natural wrap with mod 0
        restart(1'b1, 1'b0, 16'hFFFE, 16'd0);
        step(); step(); step();
        check("R4 natural wrap", {16'd0, o1_data}, 32'd0);

        // R2 lfsr from zero seed
        restart(1'b0, 1'b0, 16'd0, 16'd0);
        step(); step(); step();
        check("R2 lfsr third", {16'd0, o1_data}, 32'd3);
        step();
        check("R2 lfsr fourth", {16'd0, o1_data}, 32'd7);

        // R5 constant
        restart(1'b0, 1'b1, 16'h5A5A, 16'd0);
        for (int i = 0; i < 3; i++) begin
            step();
            check("R5 const", {16'd0, o1_data}, 32'h00005A5A);
        end
        const_sel = 1'b0; step(); step();

        // R7 request gaps, R9 latency
        restart(1'b1, 1'b0, 16'd10, 16'd0);
        step();
        check("R7 word before gap", {16'd0, o1_data}, 32'd10);
        req = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step();
            check("R7 gap no valid", {31'd0, o1_valid}, 32'd0);
            check("R7 gap holds", {16'd0, o1_data}, 32'd10);
        end
        req = 1'b1;
        #1;
        check("R9 comb same cycle", {31'd0, o0_valid}, 32'd1);
        check("R9 comb next word", {16'd0, o0_data}, 32'd11);
        check("R9 reg not yet", {31'd0, o1_valid}, 32'd0);
        step();
        check("R7 resumes", {16'd0, o1_data}, 32'd11);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            r = $urandom;
            if (r[5:0] == 6'd0) enable = ~enable;
            if (!enable && r[9:8] == 2'd0) begin
                pat_sel   = r[10];
                const_sel = (r[13:11] == 3'd0);
                mod_val   = W'(r[17:14] % 9);
                init_val  = r[31:16];
            end
            req = (r[7:6] != 2'd0);
            step();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule